// File: doc/BRIEF.md
# Double-Buffered DAC Code Loader

This block is the digital front end of a 14-bit digital-to-analog converter that sits on an 8-bit processor bus. The 14-bit code cannot arrive in one bus write, so it is collected in two input registers. The upper six bits go into one register and the lower eight bits into the other. A separate transfer write then copies both halves into the DAC register in a single clock. As a result, the converter never sees a code that mixes an old half with a new half.

A direct-load address makes every register stage take the bus in one write. This gives a quick way to force zero scale or full scale, for example during calibration. Selection uses an active-low select, an active-low write strobe and a 2-bit address. All captures happen on the rising system clock edge while select and write are both low.

The bus side is a plain strobe interface and has no back-pressure. Every qualified write is taken on the edge where it is present, and the block never stalls the bus.

Top module: `dac_code_loader`

## Requirements
- R1: Reset (rst_n low) clears the high input register, the low input register and the DAC register to zero, so `dac_code` reads 14'h0000 and a later transfer also yields 14'h0000.
- R2: While `sel_n` is high, no register changes at a clock edge, whatever `wr_n`, `addr` and `bus_d` are.
- R3: While `wr_n` is high, no register changes at a clock edge, whatever `addr` and `bus_d` are.
- R4: Address 2'b01 with select and write low loads only the high input register from `bus_d[5:0]`, and `dac_code` is unchanged.
- R5: Address 2'b10 with select and write low loads only the low input register from `bus_d[7:0]`, and `dac_code` is unchanged.
- R6: Address 2'b11 with select and write low sets `dac_code` to {high register, low register}, both taken as they stood before that edge, so all 14 bits change in one step.
- R7: Address 2'b00 with select and write low sets `dac_code` to {bus_d[5:0], bus_d[7:0]} at that edge. Both input registers capture the same bits, so a following 2'b11 transfer reproduces the same code.
- R8: A direct load of 8'h00 gives 14'h0000 (zero scale) and a direct load of 8'hFF gives 14'h3FFF (full scale), each in one write.
- R9: The code is offset binary. Loading high part 6'h20 and low part 8'h00 and then transferring gives exactly 14'h2000 (mid-scale).
- R10: Bus bits [7:6] have no effect on the high part. A high-register write of any value with those bits set, followed by a transfer, gives the same code as with those bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all captures happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 8 | Processor data bus |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select: 00 direct, 01 high, 10 low, 11 transfer |
| dac_code | output | 14 | Code sent to the converter |

## Verification
Every result is due one clock edge after the write that causes it. A direct load or a transfer shows up on `dac_code` at the first rising edge where the strobes are low. An input-register write has no output effect of its own, so it is exposed by a transfer write on the following edge. The bench drives each write on a falling edge and holds it across exactly one rising edge. It then compares `dac_code` with its own model at the next falling edge. As a result, each comparison sees exactly the state one rising edge produced.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int CODE_W_DEF = 14;
  localparam int BUS_W_DEF  = 8;

  typedef enum logic [1:0] {
    AD_DIRECT = 2'b00,
    AD_HIGH   = 2'b01,
    AD_LOW    = 2'b10,
    AD_XFER   = 2'b11
  } dac_addr_e;
endpackage

// File: rtl/dacif_decode.sv
module dacif_decode
  import dacif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  output logic       ld_hi,
  output logic       ld_lo,
  output logic       ld_out_bus,
  output logic       ld_out_buf
);
  logic      active;
  dac_addr_e code;

  assign active = ~sel_n & ~wr_n;
  assign code   = dac_addr_e'(addr);

  always_comb begin
    ld_hi      = 1'b0;
    ld_lo      = 1'b0;
    ld_out_bus = 1'b0;
    ld_out_buf = 1'b0;
    if (active) begin
      unique case (code)
        AD_DIRECT: begin ld_hi = 1'b1; ld_lo = 1'b1; ld_out_bus = 1'b1; end
        AD_HIGH:   ld_hi = 1'b1;
        AD_LOW:    ld_lo = 1'b1;
        AD_XFER:   ld_out_buf = 1'b1;
        default:   ;
      endcase
    end
  end

  AST_OUT_SOURCE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ld_out_bus, ld_out_buf}) <= 1); // R6
  AST_SELECT_GATES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !(ld_hi | ld_lo | ld_out_bus | ld_out_buf)); // R2
  AST_STROBE_GATES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |-> !(ld_hi | ld_lo | ld_out_bus | ld_out_buf)); // R3
endmodule

// File: rtl/dacif_reg.sv
module dacif_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R2
  AST_CAPTURE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> q == $past(d)); // R4
endmodule

// File: rtl/dacif_out.sv
module dacif_out #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_bus,
  input  logic         ld_buf,
  input  logic [W-1:0] bus_code,
  input  logic [W-1:0] buf_code,
  output logic [W-1:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code <= '0;
    else if (ld_bus) code <= bus_code;
    else if (ld_buf) code <= buf_code;
  end

  AST_XFER_WHOLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_buf && !ld_bus) |=> code == $past(buf_code)); // R6
  AST_DIRECT_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_bus |=> code == $past(bus_code)); // R7
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_bus || ld_buf) |=> $stable(code)); // R5
endmodule

// File: rtl/dac_code_loader.sv
module dac_code_loader
  import dacif_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int BUS_W  = BUS_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_d,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  output logic [CODE_W-1:0] dac_code
);
  localparam int LO_W = BUS_W;
  localparam int HI_W = CODE_W - LO_W;

  logic              ld_hi, ld_lo, ld_out_bus, ld_out_buf;
  logic [HI_W-1:0]   hi_q;
  logic [LO_W-1:0]   lo_q;
  logic [CODE_W-1:0] bus_code, buf_code;

  dacif_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .ld_hi      (ld_hi),
    .ld_lo      (ld_lo),
    .ld_out_bus (ld_out_bus),
    .ld_out_buf (ld_out_buf)
  );

  dacif_reg #(.W(HI_W)) u_hi (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ld_hi),
    .d     (bus_d[HI_W-1:0]),
    .q     (hi_q)
  );

  dacif_reg #(.W(LO_W)) u_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ld_lo),
    .d     (bus_d),
    .q     (lo_q)
  );

  assign bus_code = {bus_d[HI_W-1:0], bus_d};
  assign buf_code = {hi_q, lo_q};

  dacif_out #(.W(CODE_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_bus   (ld_out_bus),
    .ld_buf   (ld_out_buf),
    .bus_code (bus_code),
    .buf_code (buf_code),
    .code     (dac_code)
  );

  AST_DESELECT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> $stable(dac_code)); // R2
  AST_NO_STROBE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(dac_code)); // R3
  AST_DIRECT_SYNCS_BUFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n && addr == 2'b00) |=> buf_code == dac_code); // R7
endmodule

// File: tb/dac_code_loader_test.sv
module dac_code_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_d = 8'h00;
  logic        sel_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = 2'b00;
  logic [13:0] dac_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0]  m_hi = '0;
  logic [7:0]  m_lo = '0;
  logic [13:0] m_dac = '0;

  always #4 clk = ~clk;

  dac_code_loader uut (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .sel_n(sel_n),
    .wr_n(wr_n), .addr(addr), .dac_code(dac_code)
  );

  task automatic check(input string req, input logic [13:0] exp);
    checks++;
    if (dac_code !== exp) begin
      errors++;
      $display("FAIL %s dac_code=%h expected=%h", req, dac_code, exp);
    end
  endtask

  function automatic string tag_of(input logic s, input logic w, input logic [1:0] a);
    if (s) return "R2";
    if (w) return "R3";
    case (a)
      2'b00: return "R7";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  // called at a falling edge; holds stimulus across one rising edge
  task automatic op(input logic s, input logic w, input logic [1:0] a,
                    input logic [7:0] d, input string req);
    logic [13:0] nxt;
    sel_n = s; wr_n = w; addr = a; bus_d = d;
    nxt = m_dac;
    if (!s && !w) begin
      case (a)
        2'b00: begin m_hi = d[5:0]; m_lo = d; nxt = {d[5:0], d}; end
        2'b01: m_hi = d[5:0];
        2'b10: m_lo = d;
        default: nxt = {m_hi, m_lo};
      endcase
    end
    m_dac = nxt;
    @(negedge clk);
    check(req, m_dac);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 14'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 14'h0000);
    op(0, 0, 2'b11, 8'h5A, "R1");

    op(0, 0, 2'b00, 8'h00, "R8");
    op(0, 0, 2'b00, 8'hFF, "R8");
    check("R8", 14'h3FFF);
    op(0, 0, 2'b11, 8'h00, "R7");

    op(0, 0, 2'b01, 8'h20, "R9");
    op(0, 0, 2'b10, 8'h00, "R9");
    op(0, 0, 2'b11, 8'h00, "R9");
    check("R9", 14'h2000);

    for (int v = 0; v < 64; v++) begin
      op(0, 0, 2'b01, 8'(v) | 8'hC0, "R10");
      op(0, 0, 2'b11, 8'h00, "R10");
      check("R10", {6'(v), m_lo});
    end

    for (int c = 0; c < 16; c++) begin
      for (int d = 0; d < 256; d++) begin
        logic s, w;
        logic [1:0] a;
        s = c[3]; w = c[2]; a = c[1:0];
        op(s, w, a, 8'(d), tag_of(s, w, a));
        op(0, 0, 2'b11, 8'(255 - d), tag_of(s, w, a));
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule